// File: doc/BRIEF.md
# Dual-Enable Static Memory Model

A clocked, synthesizable stand-in for an asynchronous byte-wide static memory with a pin-style control set. The control set has two chip selects of opposite polarity, an active-low output enable and an active-low write strobe. A fast internal clock samples the pins. The decoded mode decides whether the block reads, writes, sits idle, is deselected or is in low-power standby. The bidirectional data bus is split into `din`, `dout` and `dout_oe`, so the surrounding logic can build a three-state pad, or a multiplexed bus, from them.

A write lasts for as long as both selects are valid and the write strobe is low. It is committed when that window closes, whichever of the three signals closes it. The byte and address stored are the last ones sampled inside the window, which matches the rule that input data is referenced to the closing edge. The array holds `2**ADDR_W` words of `DATA_W` bits. The 8K x 8 configuration is `ADDR_W = 13`. The default build uses a smaller depth so that it elaborates quickly. Memory contents are never cleared by reset.

Top module: `sram_dual_enable`

## Requirements
- R1: A byte committed to an address reads back unchanged from that address, and a write to one address leaves every other address unchanged.
- R2: `dout_oe` is 1 exactly when the sampled pins show `sel_n`=0, `sel`=1, `wr_n`=1 and `rd_n`=0. `dout` then carries the stored byte at the sampled address.
- R3: In every other pin combination, `dout_oe` is 0 and `dout` is 0. This includes both selects valid with `wr_n`=1 and `rd_n`=1.
- R4: The write window is open while `sel_n`=0, `sel`=1 and `wr_n`=0, regardless of `rd_n`. While it is open, `dout_oe` is 0.
- R5: When the window closes, because `sel_n` rises, `sel` falls or `wr_n` rises, the last address and byte sampled inside the window are committed. Changes to `din` during the window before its last cycle have no lasting effect.
- R6: `standby` equals the sampled `sel_n`, whatever the other pins are. While `standby` is 1, `dout_oe` is 0.
- R7: If a select and the write strobe are deasserted in the same cycle, the bus stays off (`dout_oe`=0) and the write is still committed.
- R8: A read that begins in the cycle a write window closes, at the written address, returns the new byte in that first read cycle.
- R9: Outputs follow the pins sampled at the previous rising clock edge. A pin change is not visible before that edge.
- R10: While `rst_n` is 0, `standby` is 1 and `dout_oe` is 0. A write window open at reset is dropped without being committed. Stored contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_n | input | 1 | Chip select, active low; high forces standby |
| sel | input | 1 | Chip select, active high |
| rd_n | input | 1 | Output enable, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data from the bus |
| dout | output | DATA_W | Read data to the bus, 0 when not driving |
| dout_oe | output | 1 | Bus drive enable for a read |
| standby | output | 1 | Low-power standby status |

## Verification
The bench closes write windows with each of the three qualifying signals in turn. A model that only watched the write strobe would lose the writes ended by a select, and a model that latched the first byte of a window would store stale data. It releases a select together with the strobe while the output enable is low, which catches a design that glitches the bus on. It reads an address in the very cycle its write ends, which exposes a missing forward path as a stale byte. It also asserts reset in the middle of a write and then reads the old contents, which catches designs that commit on reset or clear the array. Random pin mixes then check the bus enable, standby and data against a reference model on every cycle.

// File: rtl/sram_pkg.sv
// Shared types for the dual-enable static memory model.
// Assumes: control pins are sampled once per clock and decoded from the sampled copy.
package sram_pkg;

    // Sampled control pins, each in its pin polarity.
    typedef struct packed {
        logic sel_n;
        logic sel;
        logic wr_n;
        logic rd_n;
    } ctrl_t;

    // Control pins in their inactive (standby) state.
    localparam ctrl_t CTRL_REST = '{sel_n: 1'b1, sel: 1'b0, wr_n: 1'b1, rd_n: 1'b1};

    // Operating modes decoded from the controls.
    typedef enum logic [2:0] {
        MODE_SLEEP = 3'd0,
        MODE_OFF   = 3'd1,
        MODE_IDLE  = 3'd2,
        MODE_READ  = 3'd3,
        MODE_WRITE = 3'd4
    } mode_t;

endpackage

// File: rtl/sram_pin_sampler.sv
// Registers the pin-level inputs on the sampling clock.
// Assumes: the pins may change at any time; only the registered copy is used downstream.
module sram_pin_sampler
    import sram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctrl_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    // Capture controls; reset parks them in the standby state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_REST;
        end else begin
            ctrl_q <= ctrl_i;
        end
    end

    // Capture address and data bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else begin
            addr_q <= addr_i;
            data_q <= data_i;
        end
    end

endmodule

// File: rtl/sram_mode_decode.sv
// Decodes sampled control pins into one operating mode.
// Assumes: sel_n high overrides everything, then sel low, then the write strobe over the output enable.
module sram_mode_decode
    import sram_pkg::*;
(
    input  ctrl_t ctrl,
    output mode_t mode
);

    // Priority decode of the control set.
    always_comb begin
        if (ctrl.sel_n) begin
            mode = MODE_SLEEP;
        end else if (!ctrl.sel) begin
            mode = MODE_OFF;
        end else if (!ctrl.wr_n) begin
            mode = MODE_WRITE;
        end else if (!ctrl.rd_n) begin
            mode = MODE_READ;
        end else begin
            mode = MODE_IDLE;
        end
    end

endmodule

// File: rtl/sram_write_capture.sv
// Tracks the write window and holds its last address and byte.
// Emits a one-cycle commit in the first cycle after the window closes.
// Assumes: in_window comes from registered pins; reset drops an open window.
module sram_write_capture #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_window,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              commit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    logic open_q;

    // Remember whether the window was open in the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
        end else begin
            open_q <= in_window;
        end
    end

    // Keep overwriting the held address and byte while the window is open.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_addr <= '0;
            cap_data <= '0;
        end else if (in_window) begin
            cap_addr <= addr;
            cap_data <= data;
        end
    end

    // The window has just closed.
    assign commit = open_q & ~in_window & rst_n;

endmodule

// File: rtl/sram_array.sv
// Word storage with one write port and one combinational read port.
// Assumes: no reset of contents; depth is 2**ADDR_W.
module sram_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word when a commit is requested.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Asynchronous read of the addressed word.
    assign rdata = mem[raddr];

endmodule

// File: rtl/sram_dual_enable.sv
// Top of the dual-enable static memory model.
// Samples the pins, decodes the mode, commits a write when its window closes,
// and drives read data with a separate enable instead of a three-state bus.
// Assumes: the clock is fast compared with pin activity; one cycle of latency from pins to outputs.
module sram_dual_enable
    import sram_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sel,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              standby
);

    ctrl_t             ctrl_in;
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    mode_t             mode;
    logic              commit;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;
    logic [DATA_W-1:0] rdata;
    logic              fwd_hit;

    // Bundle the control pins.
    assign ctrl_in = '{sel_n: sel_n, sel: sel, wr_n: wr_n, rd_n: rd_n};

    sram_pin_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctrl_i (ctrl_in),
        .addr_i (addr),
        .data_i (din),
        .ctrl_q (ctrl_q),
        .addr_q (addr_q),
        .data_q (data_q)
    );

    sram_mode_decode u_decode (
        .ctrl (ctrl_q),
        .mode (mode)
    );

    sram_write_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_window (mode == MODE_WRITE),
        .addr      (addr_q),
        .data      (data_q),
        .commit    (commit),
        .cap_addr  (cap_addr),
        .cap_data  (cap_data)
    );

    sram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .we    (commit),
        .waddr (cap_addr),
        .wdata (cap_data),
        .raddr (addr_q),
        .rdata (rdata)
    );

    // Forward a byte that is being committed this cycle to a read of the same word.
    assign fwd_hit = commit && (cap_addr == addr_q);

    // Drive the bus only in read mode, and hold it at zero otherwise.
    always_comb begin
        dout_oe = (mode == MODE_READ);
        if (mode != MODE_READ) begin
            dout = '0;
        end else if (fwd_hit) begin
            dout = cap_data;
        end else begin
            dout = rdata;
        end
    end

    // Standby status follows the active-low select.
    assign standby = (mode == MODE_SLEEP);

endmodule

// File: rtl/sram_dual_enable_chk.sv
// Protocol checker for the dual-enable memory model, bound to the top.
// Assumes: synchronous active-low reset; all properties are off while reset is low.
module sram_dual_enable_chk #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              sel,
    input logic              rd_n,
    input logic              wr_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] din,
    input logic [DATA_W-1:0] dout,
    input logic              dout_oe,
    input logic              standby
);

    // R2 and R9: the bus enable follows the read condition of the previous edge.
    p_read_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dout_oe == $past(!sel_n && sel && wr_n && !rd_n)));

    // R3: when the bus is not driven, its value is zero.
    p_quiet_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe |-> (dout == '0));

    // R4: no drive while the write window was open at the previous edge.
    p_no_drive_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!sel_n && sel && !wr_n)) |-> !dout_oe);

    // R6 and R9: standby follows the sampled active-low select.
    p_standby_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (standby == $past(sel_n)));

    // R6: standby and bus drive never coexist.
    p_standby_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !dout_oe);

endmodule

bind sram_dual_enable sram_dual_enable_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .sel     (sel),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .addr    (addr),
    .din     (din),
    .dout    (dout),
    .dout_oe (dout_oe),
    .standby (standby)
);

// File: tb/sram_dual_enable_test.sv
module sram_dual_enable_test;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam int NWORDS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          sel = 1'b0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic          standby;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic [DW-1:0] model [NWORDS];
    bit            m_open = 0;
    logic [AW-1:0] m_addr = '0;
    logic [DW-1:0] m_data = '0;

    always #2 clk = ~clk;

    sram_dual_enable #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sel(sel), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .standby(standby)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit exp_read(bit s_n, bit s, bit w_n, bit r_n);
        return !s_n && s && w_n && !r_n;
    endfunction

    function automatic bit exp_write(bit s_n, bit s, bit w_n);
        return !s_n && s && !w_n;
    endfunction

    // Drive pins for one cycle, update the model, check all outputs after the edge.
    task automatic apply(bit s_n, bit s, bit w_n, bit r_n,
                         logic [AW-1:0] a, logic [DW-1:0] d, string tag);
        bit rd;
        bit wr;
        @(negedge clk);
        sel_n = s_n; sel = s; wr_n = w_n; rd_n = r_n; addr = a; din = d;
        @(posedge clk);
        #1;
        rd = exp_read(s_n, s, w_n, r_n);
        wr = exp_write(s_n, s, w_n);
        if (m_open && !wr) model[m_addr[3:0]] = m_data;
        if (wr) begin
            m_addr = a;
            m_data = d;
        end
        m_open = wr;
        chk({tag, " R6 standby"}, standby, s_n);
        chk({tag, rd ? " R2 oe" : (wr ? " R4 oe" : " R3 oe")}, dout_oe, rd);
        chk({tag, rd ? " R1 data" : " R3 data"}, dout, rd ? model[a[3:0]] : '0);
    endtask

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        // R10: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R10 standby in reset", standby, 1);
        chk("R10 oe in reset", dout_oe, 0);
        chk("R10 data in reset", dout, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Preload 16 words (R1)
        for (int i = 0; i < NWORDS; i++) begin
            apply(0, 1, 0, 1, AW'(i), DW'(8'h11 * i + 8'h05), "R1 load");
            apply(0, 1, 1, 1, AW'(i), 8'h00, "R1 load");
        end
        for (int i = 0; i < NWORDS; i++) apply(0, 1, 1, 0, AW'(i), 8'h00, "R1 readback");

        // R3: selects valid, both strobes high
        apply(0, 1, 1, 1, 11'd2, 8'h00, "R3 idle");

        // R5: window ends by sel falling, last byte of the window kept
        apply(0, 1, 0, 0, 11'd4, 8'hA1, "R5 sel end");
        apply(0, 1, 0, 0, 11'd4, 8'hB2, "R5 sel end");
        apply(0, 0, 0, 0, 11'd4, 8'hC3, "R5 sel end");
        apply(0, 1, 1, 0, 11'd4, 8'h00, "R5 sel end");
        chk("R5 last byte via sel", dout, 8'hB2);

        // R5: window ends by sel_n rising
        apply(0, 1, 0, 1, 11'd5, 8'h5A, "R5 seln end");
        apply(1, 1, 0, 1, 11'd5, 8'h00, "R5 seln end");
        apply(0, 1, 1, 0, 11'd5, 8'h00, "R5 seln end");
        chk("R5 byte via sel_n", dout, 8'h5A);

        // R7 and R8: select and strobe released together with rd_n low, then a read in the closing cycle
        apply(0, 1, 0, 0, 11'd6, 8'h6C, "R7");
        apply(1, 1, 1, 0, 11'd6, 8'h00, "R7 together");
        chk("R7 bus off", dout_oe, 0);
        apply(0, 1, 0, 0, 11'd7, 8'hE7, "R8");
        apply(0, 1, 1, 0, 11'd7, 8'h00, "R8 forward");
        chk("R8 new byte at once", dout, 8'hE7);
        apply(0, 1, 1, 0, 11'd6, 8'h00, "R7 committed");
        chk("R7 byte stored", dout, 8'h6C);

        // R9: a pin change is not visible before the next edge
        apply(0, 1, 1, 1, 11'd3, 8'h00, "R9");
        @(negedge clk);
        rd_n = 1'b0;
        #1;
        chk("R9 no early drive", dout_oe, 0);
        @(posedge clk);
        #1;
        chk("R9 drive after edge", dout_oe, 1);
        chk("R9 data after edge", dout, model[3]);

        // R10: reset during an open window drops it and keeps contents
        apply(0, 1, 0, 1, 11'd8, 8'hFF, "R10");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1;
        chk("R10 standby", standby, 1);
        chk("R10 oe", dout_oe, 0);
        @(negedge clk);
        sel_n = 1'b0; sel = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
        m_open = 0;
        rst_n = 1'b1;
        apply(0, 1, 1, 0, 11'd8, 8'h00, "R10 kept");
        chk("R10 old byte kept", dout, model[8]);

        // Random mix of pin patterns
        for (int n = 0; n < 4000; n++) begin
            bit s_n;
            bit s;
            bit w_n;
            bit r_n;
            s_n = ($urandom % 5) == 0;
            s   = ($urandom % 5) != 0;
            w_n = ($urandom % 3) != 0;
            r_n = ($urandom % 3) == 0;
            apply(s_n, s, w_n, r_n, AW'($urandom % NWORDS), DW'($urandom), "rand");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule